// File: doc/BRIEF.md
# Control-Transfer Next-PC Resolver

This block resolves where a control-transfer instruction sends the program counter and what, if anything, it writes back as a return address. Each cycle it may accept one instruction, given as an operation code, the address of the instruction after it (the sequential PC), two register operands, a 16-bit branch displacement, a 26-bit jump index and a destination register number for the one variant that names its own link register.

One clock edge after acceptance it presents four things: the resolved next PC, a taken flag, a link write (enable, value and destination register) and an address-fault flag for misaligned register jumps. Every candidate target is computed in parallel and picked by a late select.

It sits beside the execute stage of a simple in-order pipeline. It does no fetching, keeps no delay-slot state and raises no traps. The fault flag only reports.

Top module: `bj_nextpc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with `in_valid` low, every output is zero.
- R2: Outputs are registered. The values presented after a rising edge belong to the operation sampled at that edge, and `out_valid` equals `in_valid` from that edge.
- R3: A taken conditional branch yields `npc` = `seq_pc` + (sign-extended `br_off` × 4), modulo 2^32, with `taken` high.
- R4: Op codes 1 to 8 are conditional, with these conditions: 1 when `rs_val` == `rt_val`; 2 when `rs_val` != `rt_val`; 3 and 7 when signed `rs_val` >= 0; 4 when signed `rs_val` > 0; 5 when signed `rs_val` <= 0; 6 and 8 when signed `rs_val` < 0. `taken` is high exactly when the condition holds.
- R5: A conditional op whose condition fails gives `npc` = `seq_pc` and `taken` low.
- R6: Op codes 9 and 10 are absolute jumps. They are always taken, with `npc` = {`seq_pc`[31:28], `jmp_idx`, 2'b00}.
- R7: Op codes 11 and 12 are register jumps. They are always taken, with `npc` = `rs_val`.
- R8: `addr_err` is high exactly when the op is 11 or 12 and `rs_val`[1:0] is nonzero. The jump and any link still go ahead.
- R9: Op codes 7, 8 and 10 set `link_we`, with `link_val` = `seq_pc` and `link_dst` = 31. For 7 and 8 this happens whether or not the branch is taken.
- R10: Op code 12 sets `link_we`, with `link_val` = `seq_pc` and `link_dst` = `rd_sel`.
- R11: Any op other than 7, 8, 10 and 12 leaves `link_we` low and `link_val` and `link_dst` zero.
- R12: Op code 0, codes 13 to 15, and any cycle with `in_valid` low give `npc` = `seq_pc`, with `taken`, `link_we` and `addr_err` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see R4 to R12) |
| seq_pc | input | 32 | Address of the instruction after the control transfer |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_off | input | 16 | Branch displacement in words, signed |
| jmp_idx | input | 26 | Absolute jump word index |
| rd_sel | input | 5 | Link destination for op 12 |
| out_valid | output | 1 | Registered copy of `in_valid` |
| npc | output | 32 | Resolved next program counter |
| taken | output | 1 | Control leaves the sequential path |
| link_we | output | 1 | A return address is to be written |
| link_val | output | 32 | Return address value |
| link_dst | output | 5 | Return address destination register |
| addr_err | output | 1 | Register-jump target is not word aligned |

## Verification
Two functions can land in the same cycle, and both overlaps are exercised.

The first is a link write together with the branch decision. The bench provokes it by sweeping op codes 7 and 8 over operands that are zero, positive and negative, so a link often coincides with a branch that falls through. There the bench requires `link_we` high with the return address and destination 31, while `taken` stays low and `npc` stays sequential.

The second is a register jump with link (op 12) whose target is misaligned. The bench drives operand values with nonzero low bits and checks that the fault flag, the taken jump to `rs_val` and the link to `rd_sel` all appear together on the same registered output.

// File: rtl/bj_pkg.sv
package bj_pkg;

   typedef enum logic [3:0] {
      BJ_NONE   = 4'd0,
      BJ_BEQ    = 4'd1,
      BJ_BNE    = 4'd2,
      BJ_BGEZ   = 4'd3,
      BJ_BGTZ   = 4'd4,
      BJ_BLEZ   = 4'd5,
      BJ_BLTZ   = 4'd6,
      BJ_BGEZL  = 4'd7,
      BJ_BLTZL  = 4'd8,
      BJ_JABS   = 4'd9,
      BJ_JABSL  = 4'd10,
      BJ_JREG   = 4'd11,
      BJ_JREGL  = 4'd12
   } bj_op_e;

   typedef enum logic [2:0] {
      CND_EQ  = 3'd0,
      CND_NE  = 3'd1,
      CND_GEZ = 3'd2,
      CND_GTZ = 3'd3,
      CND_LEZ = 3'd4,
      CND_LTZ = 3'd5
   } bj_cnd_e;

   typedef struct packed {
      logic    is_cond;
      logic    is_abs;
      logic    is_reg;
      logic    link_fix;
      logic    link_rd;
      bj_cnd_e cnd;
   } bj_ctl_t;

   function automatic bj_ctl_t bj_decode(input logic [3:0] code);
      bj_ctl_t c;
      c = '{is_cond: 1'b0, is_abs: 1'b0, is_reg: 1'b0,
            link_fix: 1'b0, link_rd: 1'b0, cnd: CND_EQ};
      case (code)
         BJ_BEQ:   begin c.is_cond = 1'b1; c.cnd = CND_EQ;  end
         BJ_BNE:   begin c.is_cond = 1'b1; c.cnd = CND_NE;  end
         BJ_BGEZ:  begin c.is_cond = 1'b1; c.cnd = CND_GEZ; end
         BJ_BGTZ:  begin c.is_cond = 1'b1; c.cnd = CND_GTZ; end
         BJ_BLEZ:  begin c.is_cond = 1'b1; c.cnd = CND_LEZ; end
         BJ_BLTZ:  begin c.is_cond = 1'b1; c.cnd = CND_LTZ; end
         BJ_BGEZL: begin c.is_cond = 1'b1; c.cnd = CND_GEZ; c.link_fix = 1'b1; end
         BJ_BLTZL: begin c.is_cond = 1'b1; c.cnd = CND_LTZ; c.link_fix = 1'b1; end
         BJ_JABS:  begin c.is_abs = 1'b1; end
         BJ_JABSL: begin c.is_abs = 1'b1; c.link_fix = 1'b1; end
         BJ_JREG:  begin c.is_reg = 1'b1; end
         BJ_JREGL: begin c.is_reg = 1'b1; c.link_rd = 1'b1; end
         default:  ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bj_cond.sv
module bj_cond
   import bj_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit EQ_TREE = 1'b1
) (
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   input  bj_cnd_e         cnd,
   output logic            holds
);

   localparam int SIGN_BIT = XLEN - 1;

   if (XLEN < 2) begin : g_bad_xlen
      $error("bj_cond: XLEN must be at least 2");
   end

   logic same;
   logic zero;
   logic neg;

   if (EQ_TREE) begin : g_eq_tree
      logic [XLEN-1:0] diff;
      assign diff = rs_val ^ rt_val;
      assign same = ~|diff;
   end else begin : g_eq_cmp
      assign same = (rs_val == rt_val);
   end

   assign zero = ~|rs_val;
   assign neg  = rs_val[SIGN_BIT];

   always_comb begin
      case (cnd)
         CND_EQ:  holds = same;
         CND_NE:  holds = ~same;
         CND_GEZ: holds = ~neg;
         CND_GTZ: holds = ~neg & ~zero;
         CND_LEZ: holds = neg | zero;
         CND_LTZ: holds = neg;
         default: holds = 1'b0;
      endcase
   end

endmodule

// File: rtl/bj_target.sv
module bj_target
   import bj_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int OFF_W  = 16,
   parameter int JIDX_W = 26
) (
   input  bj_ctl_t           ctl,
   input  logic              cond_ok,
   input  logic [XLEN-1:0]   seq_pc,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [JIDX_W-1:0] jmp_idx,
   output logic [XLEN-1:0]   npc,
   output logic              taken,
   output logic              misalign
);

   localparam int EXT_W = XLEN - OFF_W - 2;
   localparam int SEG_W = XLEN - JIDX_W - 2;

   if (EXT_W < 0) begin : g_bad_off
      $error("bj_target: OFF_W too wide for XLEN");
   end
   if (SEG_W < 1) begin : g_bad_seg
      $error("bj_target: JIDX_W leaves no region bits");
   end

   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] abs_tgt;

   if (EXT_W > 0) begin : g_sext
      assign disp = {{EXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
   end else begin : g_nosext
      assign disp = {br_off, 2'b00};
   end

   assign br_tgt  = seq_pc + disp;
   assign abs_tgt = {seq_pc[XLEN-1 -: SEG_W], jmp_idx, 2'b00};

   always_comb begin
      npc      = seq_pc;
      taken    = 1'b0;
      misalign = 1'b0;
      if (ctl.is_cond) begin
         if (cond_ok) begin
            npc   = br_tgt;
            taken = 1'b1;
         end
      end else if (ctl.is_abs) begin
         npc   = abs_tgt;
         taken = 1'b1;
      end else if (ctl.is_reg) begin
         npc      = rs_val;
         taken    = 1'b1;
         misalign = |rs_val[1:0];
      end
   end

endmodule

// File: rtl/bj_link.sv
module bj_link
   import bj_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int REG_W    = 5,
   parameter int LINK_REG = 31
) (
   input  bj_ctl_t          ctl,
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [REG_W-1:0] rd_sel,
   output logic             we,
   output logic [XLEN-1:0]  val,
   output logic [REG_W-1:0] dst
);

   localparam logic [REG_W-1:0] FIX_DST = REG_W'(LINK_REG);

   if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
      $error("bj_link: LINK_REG does not fit REG_W");
   end

   always_comb begin
      we  = ctl.link_fix | ctl.link_rd;
      val = '0;
      dst = '0;
      if (ctl.link_fix) begin
         val = seq_pc;
         dst = FIX_DST;
      end else if (ctl.link_rd) begin
         val = seq_pc;
         dst = rd_sel;
      end
   end

endmodule

// File: rtl/bj_nextpc_unit.sv
module bj_nextpc_unit
   import bj_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int OFF_W    = 16,
   parameter int JIDX_W   = 26,
   parameter int REG_W    = 5,
   parameter int LINK_REG = 31,
   parameter bit EQ_TREE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [XLEN-1:0]   seq_pc,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [XLEN-1:0]   rt_val,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [JIDX_W-1:0] jmp_idx,
   input  logic [REG_W-1:0]  rd_sel,
   output logic              out_valid,
   output logic [XLEN-1:0]   npc,
   output logic              taken,
   output logic              link_we,
   output logic [XLEN-1:0]   link_val,
   output logic [REG_W-1:0]  link_dst,
   output logic              addr_err
);

   bj_ctl_t         ctl;
   logic            cond_ok;
   logic [XLEN-1:0] npc_c;
   logic            taken_c;
   logic            mis_c;
   logic            lwe_c;
   logic [XLEN-1:0] lval_c;
   logic [REG_W-1:0] ldst_c;

   assign ctl = bj_decode(in_valid ? op : 4'(BJ_NONE));

   bj_cond #(.XLEN(XLEN), .EQ_TREE(EQ_TREE)) u_cond (
      .rs_val (rs_val),
      .rt_val (rt_val),
      .cnd    (ctl.cnd),
      .holds  (cond_ok)
   );

   bj_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
      .ctl      (ctl),
      .cond_ok  (cond_ok),
      .seq_pc   (seq_pc),
      .rs_val   (rs_val),
      .br_off   (br_off),
      .jmp_idx  (jmp_idx),
      .npc      (npc_c),
      .taken    (taken_c),
      .misalign (mis_c)
   );

   bj_link #(.XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)) u_link (
      .ctl    (ctl),
      .seq_pc (seq_pc),
      .rd_sel (rd_sel),
      .we     (lwe_c),
      .val    (lval_c),
      .dst    (ldst_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         npc       <= '0;
         taken     <= 1'b0;
         link_we   <= 1'b0;
         link_val  <= '0;
         link_dst  <= '0;
         addr_err  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         npc       <= npc_c;
         taken     <= taken_c;
         link_we   <= lwe_c;
         link_val  <= lval_c;
         link_dst  <= ldst_c;
         addr_err  <= mis_c;
      end
   end

endmodule

// File: rtl/bj_nextpc_chk.sv
module bj_nextpc_chk #(
   parameter int XLEN  = 32,
   parameter int REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [XLEN-1:0]  seq_pc,
   input logic             out_valid,
   input logic [XLEN-1:0]  npc,
   input logic             taken,
   input logic             link_we,
   input logic [XLEN-1:0]  link_val,
   input logic [REG_W-1:0] link_dst,
   input logic             addr_err
);

   logic seen;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> out_valid == $past(in_valid)); // R2

   AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !taken) |-> npc == $past(seq_pc)); // R5

   AST_LINK_RETADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && link_we) |-> link_val == $past(seq_pc)); // R9

   AST_FAULT_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (taken && npc[1:0] != 2'b00)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!taken && !link_we && !addr_err)); // R12

   AST_NOLINK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !link_we |-> (link_val == '0 && link_dst == '0)); // R11

endmodule

bind bj_nextpc_unit bj_nextpc_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .seq_pc    (seq_pc),
   .out_valid (out_valid),
   .npc       (npc),
   .taken     (taken),
   .link_we   (link_we),
   .link_val  (link_val),
   .link_dst  (link_dst),
   .addr_err  (addr_err)
);

// File: tb/bj_nextpc_unit_test.sv
module bj_nextpc_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] seq_pc = '0, rs_val = '0, rt_val = '0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_idx = '0;
   logic [4:0]  rd_sel = '0;
   logic        out_valid, taken, link_we, addr_err;
   logic [31:0] npc, link_val;
   logic [4:0]  link_dst;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bj_nextpc_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .seq_pc(seq_pc), .rs_val(rs_val), .rt_val(rt_val), .br_off(br_off),
      .jmp_idx(jmp_idx), .rd_sel(rd_sel), .out_valid(out_valid), .npc(npc),
      .taken(taken), .link_we(link_we), .link_val(link_val),
      .link_dst(link_dst), .addr_err(addr_err)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h (op=%0d rs=%h rt=%h off=%h seq=%h)",
                  tag, what, act, exp, op, rs_val, rt_val, br_off, seq_pc);
      end
   endtask

   function automatic logic [31:0] pick_rs(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h0000_0002;
         3: return 32'hFFFF_FFFF;
         4: return 32'h8000_0000;
         5: return 32'h7FFF_FFFF;
         6: return 32'h0000_1004;
         default: return 32'hFFFF_FFFC;
      endcase
   endfunction

   function automatic logic [15:0] pick_off(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h7FFF;
         3: return 16'h8000;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [31:0] pick_seq(input int i);
      case (i % 3)
         0: return 32'h0040_0010;
         1: return 32'hF000_0004;
         default: return 32'hFFFF_FFF8;
      endcase
   endfunction

   // Expected results computed from the requirements only
   task automatic apply_and_check(input int code);
      logic [31:0] e_npc, e_lval;
      logic        e_tk, e_lwe, e_err, cond;
      logic [4:0]  e_ldst;
      string       t_npc, t_tk, t_lnk;
      int          s;
      s      = $signed(rs_val);
      cond   = 1'b0;
      e_npc  = seq_pc;
      e_tk   = 1'b0;
      e_err  = 1'b0;
      e_lwe  = 1'b0;
      e_lval = 32'd0;
      e_ldst = 5'd0;
      t_npc  = "R12";
      t_tk   = "R12";
      t_lnk  = "R11";
      if (code >= 1 && code <= 8) begin
         case (code)
            1: cond = (rs_val == rt_val);
            2: cond = (rs_val != rt_val);
            3, 7: cond = (s >= 0);
            4: cond = (s > 0);
            5: cond = (s <= 0);
            default: cond = (s < 0);
         endcase
         t_tk = "R4";
         if (cond) begin
            e_tk  = 1'b1;
            e_npc = seq_pc + ($signed({{16{br_off[15]}}, br_off}) * 4);
            t_npc = "R3";
         end else begin
            t_npc = "R5";
         end
      end else if (code == 9 || code == 10) begin
         e_tk  = 1'b1;
         e_npc = (seq_pc & 32'hF000_0000) | ({6'd0, jmp_idx} << 2);
         t_npc = "R6";
         t_tk  = "R6";
      end else if (code == 11 || code == 12) begin
         e_tk  = 1'b1;
         e_npc = rs_val;
         e_err = (rs_val % 4) != 0;
         t_npc = "R7";
         t_tk  = "R7";
      end
      if (code == 7 || code == 8 || code == 10) begin
         e_lwe = 1'b1; e_lval = seq_pc; e_ldst = 5'd31; t_lnk = "R9";
      end else if (code == 12) begin
         e_lwe = 1'b1; e_lval = seq_pc; e_ldst = rd_sel; t_lnk = "R10";
      end
      in_valid = 1'b1;
      op       = code[3:0];
      @(posedge clk);
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd1, "R2", "out_valid");
      chk(npc, e_npc, t_npc, "npc");
      chk({31'd0, taken}, {31'd0, e_tk}, t_tk, "taken");
      chk({31'd0, addr_err}, {31'd0, e_err}, "R8", "addr_err");
      chk({31'd0, link_we}, {31'd0, e_lwe}, t_lnk, "link_we");
      chk(link_val, e_lval, t_lnk, "link_val");
      chk({27'd0, link_dst}, {27'd0, e_ldst}, t_lnk, "link_dst");
   endtask

   task automatic idle_check;
      in_valid = 1'b0;
      op       = 4'd12;
      rs_val   = 32'h0000_0003;
      @(posedge clk);
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R2", "idle out_valid");
      chk(npc, seq_pc, "R12", "idle npc");
      chk({29'd0, taken, link_we, addr_err}, 32'd0, "R12", "idle flags");
   endtask

   initial begin
      int n;
      n = 0;
      repeat (3) @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R1", "reset out_valid");
      chk(npc, 32'd0, "R1", "reset npc");
      chk({29'd0, taken, link_we, addr_err}, 32'd0, "R1", "reset flags");
      chk(link_val, 32'd0, "R1", "reset link_val");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R1", "post-reset out_valid");
      chk(npc, 32'd0, "R1", "post-reset npc");
      for (int c = 0; c < 16; c++) begin
         for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 4; b++) begin
               for (int o = 0; o < 5; o++) begin
                  seq_pc  = pick_seq(n);
                  rs_val  = pick_rs(a);
                  rt_val  = (b == 3) ? rs_val : pick_rs((a + b + 3) % 8);
                  br_off  = pick_off(o);
                  jmp_idx = (n % 2 == 0) ? 26'h3FF_FFFF : 26'h123_4567;
                  rd_sel  = 5'(n);
                  apply_and_check(c);
                  n++;
               end
            end
         end
         idle_check();
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule